// File: doc/BRIEF.md
# Serial Channel FIFO Pair with DMA Ready Signalling

This block holds the two 16-entry character queues of one serial channel: a transmit queue filled by the host and drained by the serializer, and a receive queue filled by the deserializer and drained by the host. It turns the fill levels of these queues into two active-low ready lines and one interrupt request. A host or DMA engine uses these signals to move characters either one at a time or in bursts.

Two signalling styles are available. In per-character style, the receive ready line is asserted whenever anything is waiting. The transmit ready line is asserted only once the transmit queue has fully drained, and the interrupt pulses on every character the serial side moves. In block style, transmit ready stays asserted while there is any free slot. Receive ready and the interrupt follow a programmable receive threshold, so a DMA engine can move a burst per request. The block also reports whether the transmit side has room and whether it is completely idle, and it flags characters lost to a full receive queue.

Top module: `chan_fifo_dma`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `txrdy_n`=0, `rxrdy_n`=1, `irq`=0, `rx_overrun`=0, `tx_space`=1 and `tx_idle`=1, and both queues are empty.
- R2: Each queue holds up to 16 characters and returns them in write order. Read data (`host_rdata`, `ser_tx_data`) is registered and valid in the cycle after the accepted pop. A pop from an empty queue is ignored.
- R3: A host write to a transmit queue holding 16 characters is discarded, even if the serializer pops in the same cycle. The stored characters are unchanged.
- R4: A receive push into a full queue is dropped and sets `rx_overrun`, which stays set until `rx_clr` or `rst`. The stored characters are unchanged.
- R5: `tx_clr` empties only the transmit queue. `rx_clr` empties only the receive queue and clears `rx_overrun`. A clear takes effect at the same clock edge and wins over a push or pop in that cycle.
- R6: Per-character style (`dma_mode`=0): `rxrdy_n` is low exactly when the receive queue holds at least one character.
- R7: Per-character style: `txrdy_n` is low only when the transmit queue is empty.
- R8: Block style (`dma_mode`=1 and `fifo_en`=1): `txrdy_n` is low while the transmit queue holds fewer than 16 characters.
- R9: Block style: `rxrdy_n` is low when the receive count is at or above the threshold chosen by `rx_trig`: 0 selects 1, 1 selects 4, 2 selects 8, and 3 selects 14.
- R10: Per-character style: `irq` is a one-cycle pulse in the cycle after each accepted receive push or transmit pop. It stays low otherwise.
- R11: Block style: `irq` is high while the receive count is at or above the `rx_trig` threshold.
- R12: `tx_space` is high while the transmit queue holds fewer than 16 characters. `tx_idle` is high when the transmit queue is empty and `ser_busy` is low.
- R13: When `fifo_en` is low, `dma_mode` is ignored and per-character signalling applies.
- R14: `txrdy_n`, `rxrdy_n`, `irq`, `tx_space` and `tx_idle` are registered. They reflect the queue counts and control inputs one clock after those change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue enable; low forces per-character signalling |
| dma_mode | input | 1 | 0 per-character, 1 block signalling |
| rx_trig | input | 2 | Receive threshold select (1, 4, 8, 14) |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue and clear overrun |
| host_wr | input | 1 | Host write strobe into transmit queue |
| host_wdata | input | 8 | Host write character |
| host_rd | input | 1 | Host read strobe from receive queue |
| host_rdata | output | 8 | Character read from receive queue |
| ser_tx_pop | input | 1 | Serializer takes a character |
| ser_tx_data | output | 8 | Character handed to the serializer |
| ser_busy | input | 1 | Serializer shift register still sending |
| ser_rx_push | input | 1 | Deserializer delivers a character |
| ser_rx_data | input | 8 | Delivered character |
| txrdy_n | output | 1 | Transmit ready, active low |
| rxrdy_n | output | 1 | Receive ready, active low |
| irq | output | 1 | Interrupt request |
| tx_space | output | 1 | Transmit queue has a free slot |
| tx_idle | output | 1 | Transmit queue and serializer both empty |
| rx_overrun | output | 1 | Sticky lost-character flag |

## Verification
The assertions assume that `rst` is applied before the first checked edge and that strobes are clean single-cycle levels sampled at the rising edge. They place no limit on a push to a full queue, because the design is defined to handle that case. The bench changes every input half a cycle away from the sampling edge. It moves to a new signalling style only after clearing both queues, so each ready-line check starts from a known count. It reaches the full-queue cases by writing exactly 16 characters before the extra one.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/cfd_sync_fifo.sv
module cfd_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push && !full && !clr;
  assign rd_ok = pop && !empty && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= bump(wp);
      if (rd_ok) rp <= bump(rp);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> $stable(count));

endmodule

// File: rtl/cfd_ready_gen.sv
module cfd_ready_gen import cfd_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          tx_evt,
  input  logic          rx_evt,
  input  logic          ser_busy,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  output logic          irq,
  output logic          tx_space,
  output logic          tx_idle
);

  logic          block_mode;
  logic [CW-1:0] trig;
  logic          rx_hit;

  assign block_mode = fifo_en && dma_mode;
  assign trig       = CW'(trig_level(trig_sel));
  assign rx_hit     = (rx_cnt >= trig);

  always_ff @(posedge clk) begin
    if (rst) begin
      txrdy_n  <= 1'b0;
      rxrdy_n  <= 1'b1;
      irq      <= 1'b0;
      tx_space <= 1'b1;
      tx_idle  <= 1'b1;
    end else begin
      if (block_mode) begin
        txrdy_n <= (tx_cnt >= CW'(DEPTH));
        rxrdy_n <= !rx_hit;
        irq     <= rx_hit;
      end else begin
        txrdy_n <= (tx_cnt != '0);
        rxrdy_n <= (rx_cnt == '0);
        irq     <= tx_evt || rx_evt;
      end
      tx_space <= (tx_cnt < CW'(DEPTH));
      tx_idle  <= (tx_cnt == '0) && !ser_busy;
    end
  end

  assert_txrdy_block_R8: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && tx_cnt < CW'(DEPTH)) |=> !txrdy_n);

  assert_rxrdy_char_R6: assert property (@(posedge clk) disable iff (rst)
    (!(fifo_en && dma_mode) && rx_cnt == '0) |=> rxrdy_n);

endmodule

// File: rtl/chan_fifo_dma.sv
module chan_fifo_dma #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              dma_mode,
  input  logic [1:0]        rx_trig,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ser_tx_pop,
  output logic [DATA_W-1:0] ser_tx_data,
  input  logic              ser_busy,
  input  logic              ser_rx_push,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic              txrdy_n,
  output logic              rxrdy_n,
  output logic              irq,
  output logic              tx_space,
  output logic              tx_idle,
  output logic              rx_overrun
);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_evt, rx_evt;

  cfd_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(host_wr), .wdata(host_wdata),
    .pop(ser_tx_pop), .rdata(ser_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  cfd_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(ser_rx_push), .wdata(ser_rx_data),
    .pop(host_rd), .rdata(host_rdata),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_evt = ser_tx_pop && !tx_empty && !tx_clr;
  assign rx_evt = ser_rx_push && !rx_full && !rx_clr;

  always_ff @(posedge clk) begin
    if (rst || rx_clr) rx_overrun <= 1'b0;
    else if (ser_rx_push && rx_full) rx_overrun <= 1'b1;
  end

  cfd_ready_gen #(.DEPTH(DEPTH)) u_ready (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .trig_sel(rx_trig), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .ser_busy(ser_busy),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .irq(irq),
    .tx_space(tx_space), .tx_idle(tx_idle)
  );

  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_rx_push && rx_full && !rx_clr) |=> rx_overrun);

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !rx_clr) |=> rx_overrun);

endmodule

// File: tb/chan_fifo_dma_tb.sv
module chan_fifo_dma_tb;

  logic       clk = 1'b0;
  logic       rst, fifo_en, dma_mode, tx_clr, rx_clr;
  logic [1:0] rx_trig;
  logic       host_wr, host_rd, ser_tx_pop, ser_busy, ser_rx_push;
  logic [7:0] host_wdata, ser_rx_data, host_rdata, ser_tx_data;
  logic       txrdy_n, rxrdy_n, irq, tx_space, tx_idle, rx_overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  chan_fifo_dma u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .rx_trig(rx_trig), .tx_clr(tx_clr), .rx_clr(rx_clr),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .ser_busy(ser_busy), .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n), .irq(irq),
    .tx_space(tx_space), .tx_idle(tx_idle), .rx_overrun(rx_overrun)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d; tick(1); host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] d);
    host_rd = 1'b1; tick(1); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic ser_pop(output logic [7:0] d);
    ser_tx_pop = 1'b1; tick(1); ser_tx_pop = 1'b0; d = ser_tx_data;
  endtask

  task automatic ser_push(input logic [7:0] d);
    ser_rx_push = 1'b1; ser_rx_data = d; tick(1); ser_rx_push = 1'b0;
  endtask

  task automatic clear_both();
    tx_clr = 1'b1; rx_clr = 1'b1; tick(1); tx_clr = 1'b0; rx_clr = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(3);
    check("R1 txrdy_n in reset", txrdy_n, 0);
    check("R1 rxrdy_n in reset", rxrdy_n, 1);
    rst = 1'b0; tick(1);
    check("R1 irq", irq, 0);
    check("R1 overrun", rx_overrun, 0);
    check("R1 tx_space", tx_space, 1);
    check("R1 tx_idle", tx_idle, 1);
    check("R1 txrdy_n", txrdy_n, 0);
    check("R1 rxrdy_n", rxrdy_n, 1);
  endtask

  task automatic t_order();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) host_write(8'h30 + 8'(i));
    for (int i = 0; i < 16; i++) begin
      ser_pop(d);
      check("R2 tx order", d, 8'h30 + 8'(i));
    end
    ser_pop(d);
    check("R2 pop on empty keeps data", d, 8'h3F);
    for (int i = 0; i < 5; i++) ser_push(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      host_read(d);
      check("R2 rx order", d, 8'hA0 + 8'(i));
    end
    tick(1);
    check("R2 rx empty after drain", rxrdy_n, 1);
  endtask

  task automatic t_tx_full();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) host_write(8'(i));
    tick(1);
    check("R12 tx_space full", tx_space, 0);
    host_wr = 1'b1; host_wdata = 8'hEE; ser_tx_pop = 1'b1; tick(1);
    host_wr = 1'b0; ser_tx_pop = 1'b0;
    check("R3 pop beside dropped write", ser_tx_data, 8'h00);
    for (int i = 1; i < 16; i++) begin
      ser_pop(d);
      check("R3 stored data kept", d, 8'(i));
    end
    tick(1);
    check("R3 queue empty, extra write dropped", tx_idle, 1);
    check("R12 tx_space empty", tx_space, 1);
  endtask

  task automatic t_rx_overrun();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) ser_push(8'h60 + 8'(i));
    check("R4 no overrun at 16", rx_overrun, 0);
    ser_push(8'h55);
    check("R4 overrun set", rx_overrun, 1);
    for (int i = 0; i < 16; i++) begin
      host_read(d);
      check("R4 stored data kept", d, 8'h60 + 8'(i));
    end
    tick(1);
    check("R4 overrun sticky", rx_overrun, 1);
    check("R4 nothing extra stored", rxrdy_n, 1);
    rx_clr = 1'b1; tick(1); rx_clr = 1'b0;
    check("R5 rx_clr clears overrun", rx_overrun, 0);
  endtask

  task automatic t_clr();
    logic [7:0] d;
    host_write(8'h11); host_write(8'h12); host_write(8'h13);
    ser_push(8'hC1); ser_push(8'hC2);
    tx_clr = 1'b1; tick(1); tx_clr = 1'b0; tick(1);
    check("R5 tx cleared", tx_idle, 1);
    check("R5 rx untouched", rxrdy_n, 0);
    host_read(d); check("R5 rx data 0", d, 8'hC1);
    host_read(d); check("R5 rx data 1", d, 8'hC2);
    host_write(8'h21);
    rx_clr = 1'b1; ser_rx_push = 1'b1; ser_rx_data = 8'h77; tick(1);
    rx_clr = 1'b0; ser_rx_push = 1'b0; tick(1);
    check("R5 clear wins over push", rxrdy_n, 1);
    check("R5 rx_clr leaves tx", tx_idle, 0);
    ser_pop(d); check("R5 tx data after rx_clr", d, 8'h21);
  endtask

  task automatic t_mode0();
    logic [7:0] d;
    dma_mode = 1'b0; clear_both();
    check("R6 empty rx not ready", rxrdy_n, 1);
    ser_push(8'h01); tick(1);
    check("R6 one char ready", rxrdy_n, 0);
    host_write(8'h02); tick(1);
    check("R7 tx not empty not ready", txrdy_n, 1);
    ser_pop(d); tick(1);
    check("R7 tx empty ready", txrdy_n, 0);
    host_read(d); tick(1);
    check("R6 drained not ready", rxrdy_n, 1);
  endtask

  task automatic t_irq0();
    logic [7:0] d;
    dma_mode = 1'b0; clear_both();
    check("R10 idle irq low", irq, 0);
    ser_push(8'h5A);
    check("R10 pulse on push", irq, 1);
    tick(1);
    check("R10 pulse one cycle", irq, 0);
    host_write(8'h5B); tick(1);
    check("R10 no pulse on host write", irq, 0);
    ser_pop(d);
    check("R10 pulse on pop", irq, 1);
    tick(1);
    check("R10 pop pulse one cycle", irq, 0);
    clear_both();
  endtask

  task automatic t_mode1_tx();
    dma_mode = 1'b1; clear_both();
    for (int i = 0; i < 15; i++) host_write(8'(i));
    tick(1);
    check("R8 ready at 15", txrdy_n, 0);
    host_write(8'hF0); tick(1);
    check("R8 not ready at 16", txrdy_n, 1);
    clear_both();
    check("R8 ready after clear", txrdy_n, 0);
  endtask

  task automatic t_mode1_rx();
    int lvl [4] = '{1, 4, 8, 14};
    dma_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rx_trig = 2'(s); clear_both();
      for (int i = 0; i < lvl[s] - 1; i++) ser_push(8'(i));
      tick(1);
      check("R9 below threshold", rxrdy_n, 1);
      check("R11 irq below threshold", irq, 0);
      ser_push(8'hFF); tick(1);
      check("R9 at threshold", rxrdy_n, 0);
      check("R11 irq at threshold", irq, 1);
    end
    clear_both();
  endtask

  task automatic t_status();
    dma_mode = 1'b0; clear_both();
    ser_busy = 1'b1; tick(1);
    check("R12 busy serializer not idle", tx_idle, 0);
    check("R12 busy keeps space", tx_space, 1);
    ser_busy = 1'b0; tick(1);
    check("R12 idle again", tx_idle, 1);
  endtask

  task automatic t_fifo_dis();
    fifo_en = 1'b0; dma_mode = 1'b1; rx_trig = 2'd3; clear_both();
    host_write(8'h44); ser_push(8'h45); tick(1);
    check("R13 tx uses per-char rule", txrdy_n, 1);
    check("R13 rx uses per-char rule", rxrdy_n, 0);
    fifo_en = 1'b1; tick(1);
    check("R14 style change one clock later", txrdy_n, 0);
    check("R14 rx below 14 in block style", rxrdy_n, 1);
    clear_both();
  endtask

  initial begin
    rst = 1'b1; fifo_en = 1'b1; dma_mode = 1'b0; rx_trig = 2'd0;
    tx_clr = 1'b0; rx_clr = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; ser_tx_pop = 1'b0; ser_busy = 1'b0;
    ser_rx_push = 1'b0; ser_rx_data = '0;
    tick(1);
    t_reset();
    t_order();
    t_tx_full();
    t_rx_overrun();
    t_clr();
    t_mode0();
    t_irq0();
    t_mode1_tx();
    t_mode1_rx();
    t_status();
    t_fifo_dis();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule